// File: doc/BRIEF.md
# Control Endpoint IN Data-Stage Handler

This block owns the transmit side of USB endpoint zero while a control transfer is in its IN data stage. Firmware loads up to one packet of bytes into a local buffer, confirms that the setup stage has been handled, and then arms the packet with a single strobe. Each IN token from the protocol engine gets either the armed packet, streamed out as bytes, or a NAK. The block then waits for the host's ACK before it marks the packet complete and raises an interrupt.

Two firmware steps gate every transmission: a sticky setup-acknowledge bit and a per-packet arm strobe. A packet shorter than the maximum size, including an empty one, is sent as a normal packet, so firmware can end a transfer whose length is an exact multiple of the packet size. An OUT token ends the data stage and drops any unsent data. A SETUP token returns the block to idle at any time. If the ACK never arrives, the packet stays armed and is sent again on the next IN token.

Top module: `ep0_in_stage`

## Requirements
- R1: After reset, tx_valid, nak_out, done_flag, irq, wr_err, stage_done and armed are 0, and fill_count is 0.
- R2: An IN token that arrives while the setup-acknowledge bit is clear is answered by nak_out high for one cycle, on the cycle after the token. No byte is sent, even when a packet is armed.
- R3: An IN token with no armed packet is answered by nak_out on the next cycle. fill_count and armed do not change.
- R4: Each accepted firmware write increments fill_count. One fw_arm strobe arms the loaded packet. An accepted IN streams the bytes in write order on tx_data with a valid/ready handshake, and tx_last is high on the final byte only. Data is held while tx_ready is low.
- R5: An hs_ack after the last byte has been accepted sets done_flag and irq on the next cycle, and returns fill_count and armed to 0.
- R6: fw_done_clr clears done_flag, and irq with it. If an ACK and a clear land in the same cycle, the flag ends up set.
- R7: A write while a packet is armed, or a write when the buffer already holds MAX_PKT bytes, is dropped and sets wr_err. The buffer contents and fill_count stay as they were.
- R8: A packet armed with fewer than MAX_PKT bytes is sent as a complete packet. A packet armed with an empty buffer is sent as one beat with tx_zlp=1, tx_last=1 and tx_data=0.
- R9: An OUT token drops tx_valid, clears fill_count and armed, and sets stage_done.
- R10: A SETUP token clears the buffer, the armed state, the setup-acknowledge bit, wr_err and stage_done. It leaves done_flag unchanged.
- R11: If no ACK arrives within ACK_TIMEOUT cycles after the last byte is accepted, done_flag stays clear and the packet stays armed. The next IN token resends the same bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fw_wr_en | input | 1 | Firmware byte write strobe |
| fw_wr_data | input | 8 | Firmware byte to load |
| fw_arm | input | 1 | Arm the loaded packet (one packet per strobe) |
| fw_setup_ack | input | 1 | Set the setup-acknowledge bit |
| fw_done_clr | input | 1 | Clear the transmit-complete flag |
| tok_setup | input | 1 | SETUP token seen |
| tok_in | input | 1 | IN token seen |
| tok_out | input | 1 | OUT token seen |
| hs_ack | input | 1 | Host ACK handshake seen |
| tx_ready | input | 1 | Byte sink ready |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final beat of the packet |
| tx_zlp | output | 1 | Beat stands for a zero-length packet |
| nak_out | output | 1 | One-cycle NAK answer to an IN token |
| done_flag | output | 1 | Transmit-complete flag |
| irq | output | 1 | Interrupt request |
| wr_err | output | 1 | A write was dropped |
| stage_done | output | 1 | Data stage ended by OUT token |
| fill_count | output | $clog2(MAX_PKT+1) | Bytes currently loaded |
| armed | output | 1 | A packet is armed and not yet acknowledged |

## Verification
A wrong read pointer or byte count shows on the first packet as a byte out of order or as tx_last on the wrong beat, and the scoreboard catches it on that beat. A state machine that forgets the setup-acknowledge bit or its armed state shows as a missing or extra NAK one cycle after the token, or as bytes appearing where none were expected. Mistakes in the flag logic show on done_flag and irq one cycle after the ACK, the clear or the timeout. A broken buffer guard shows in the data of the next packet sent.

// File: rtl/ep0in_pkg.sv
package ep0in_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2,
        ST_WAIT  = 2'd3
    } ep0in_state_e;

    function automatic bit ep0in_maxp_ok(input int unsigned m);
        return (m == 8) || (m == 16) || (m == 32) || (m == 64);
    endfunction
endpackage

// File: rtl/ep0in_pkt_buf.sv
module ep0in_pkt_buf #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ep0in_ack_timer.sv
module ep0in_ack_timer #(
    parameter int unsigned LIMIT = 16,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (!expired) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R11: the counter is held at zero outside the wait window
    assert_timer_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/ep0_in_stage.sv
module ep0_in_stage
    import ep0in_pkg::*;
#(
    parameter int unsigned MAX_PKT     = 8,
    parameter int unsigned ACK_TIMEOUT = 16,
    localparam int unsigned AW         = $clog2(MAX_PKT),
    localparam int unsigned CW         = $clog2(MAX_PKT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_wr_en,
    input  logic [7:0]    fw_wr_data,
    input  logic          fw_arm,
    input  logic          fw_setup_ack,
    input  logic          fw_done_clr,
    input  logic          tok_setup,
    input  logic          tok_in,
    input  logic          tok_out,
    input  logic          hs_ack,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          tx_zlp,
    output logic          nak_out,
    output logic          done_flag,
    output logic          irq,
    output logic          wr_err,
    output logic          stage_done,
    output logic [CW-1:0] fill_count,
    output logic          armed
);
    initial begin
        assert_maxp_legal: assert (ep0in_maxp_ok(MAX_PKT));
    end

    typedef struct packed {
        ep0in_state_e  st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] rd;
        logic          sack;
        logic          done;
        logic          err;
        logic          sdone;
        logic          nak;
    } regs_t;

    regs_t r_d, r_q;

    logic       wr_ok;
    logic       buf_we;
    logic       last_beat;
    logic       zlp;
    logic       ack_expired;
    logic [7:0] buf_rdata;

    ep0in_pkt_buf #(.DEPTH(MAX_PKT), .WIDTH(8)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (r_q.cnt[AW-1:0]),
        .wdata (fw_wr_data),
        .raddr (r_q.rd),
        .rdata (buf_rdata)
    );

    ep0in_ack_timer #(.LIMIT(ACK_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == ST_WAIT),
        .expired (ack_expired)
    );

    always_comb begin
        wr_ok     = fw_wr_en && (r_q.st == ST_IDLE) && (r_q.cnt < CW'(MAX_PKT));
        buf_we    = wr_ok && !tok_setup && !tok_out;
        zlp       = (r_q.cnt == '0);
        last_beat = zlp || (CW'(r_q.rd) == r_q.cnt - CW'(1));

        r_d     = r_q;
        r_d.nak = 1'b0;

        if (fw_setup_ack) r_d.sack = 1'b1;
        if (fw_done_clr)  r_d.done = 1'b0;
        if (fw_wr_en && !wr_ok) r_d.err = 1'b1;
        if (wr_ok) r_d.cnt = r_q.cnt + CW'(1);

        if (tok_in && !(r_q.st == ST_ARMED && r_q.sack) && r_q.st != ST_SEND) begin
            r_d.nak = 1'b1;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (fw_arm) r_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (tok_in && r_q.sack) begin
                    r_d.st = ST_SEND;
                    r_d.rd = '0;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (last_beat) r_d.st = ST_WAIT;
                    else           r_d.rd = r_q.rd + AW'(1);
                end
            end
            ST_WAIT: begin
                if (hs_ack) begin
                    r_d.st   = ST_IDLE;
                    r_d.cnt  = '0;
                    r_d.rd   = '0;
                    r_d.done = 1'b1;
                end else if (ack_expired) begin
                    r_d.st = ST_ARMED;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (tok_out) begin
            r_d.st    = ST_IDLE;
            r_d.cnt   = '0;
            r_d.rd    = '0;
            r_d.sdone = 1'b1;
            r_d.nak   = 1'b0;
        end

        if (tok_setup) begin
            r_d.st    = ST_IDLE;
            r_d.cnt   = '0;
            r_d.rd    = '0;
            r_d.sack  = 1'b0;
            r_d.err   = 1'b0;
            r_d.sdone = 1'b0;
            r_d.nak   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, rd: '0, sack: 1'b0, done: 1'b0,
                     err: 1'b0, sdone: 1'b0, nak: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid   = (r_q.st == ST_SEND);
    assign tx_data    = zlp ? 8'h00 : buf_rdata;
    assign tx_last    = tx_valid && last_beat;
    assign tx_zlp     = tx_valid && zlp;
    assign nak_out    = r_q.nak;
    assign done_flag  = r_q.done;
    assign irq        = r_q.done;
    assign wr_err     = r_q.err;
    assign stage_done = r_q.sdone;
    assign fill_count = r_q.cnt;
    assign armed      = (r_q.st != ST_IDLE);

    assert_nak_without_sack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tok_in && !r_q.sack && !tok_setup && !tok_out |=> nak_out);

    assert_tx_needs_sack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> r_q.sack);

    assert_hold_under_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !tok_setup && !tok_out
        |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    assert_done_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(hs_ack && r_q.st == ST_WAIT));

    assert_full_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fw_wr_en && r_q.cnt == CW'(MAX_PKT) && !tok_setup && !tok_out
        |=> wr_err && $stable(fill_count));

    assert_zlp_single_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_zlp |-> tx_last && tx_data == 8'h00);

    assert_out_ends_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out && !tok_setup |=> !tx_valid && stage_done && fill_count == '0);

    assert_setup_keeps_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tok_setup && !hs_ack && !fw_done_clr |=> done_flag == $past(done_flag) && !armed);

    assert_timeout_rearms_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_expired && !hs_ack && !tok_setup && !tok_out
        |=> r_q.st == ST_ARMED && $stable(fill_count));
endmodule

// File: tb/ep0_in_stage_test.sv
module ep0_in_stage_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 8;
    localparam int TMO        = 16;
    localparam int CW         = $clog2(MAXP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fw_wr_en = 1'b0;
    logic [7:0]    fw_wr_data = '0;
    logic          fw_arm = 1'b0;
    logic          fw_setup_ack = 1'b0;
    logic          fw_done_clr = 1'b0;
    logic          tok_setup = 1'b0;
    logic          tok_in = 1'b0;
    logic          tok_out = 1'b0;
    logic          hs_ack = 1'b0;
    logic          tx_ready = 1'b0;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_last;
    logic          tx_zlp;
    logic          nak_out;
    logic          done_flag;
    logic          irq;
    logic          wr_err;
    logic          stage_done;
    logic [CW-1:0] fill_count;
    logic          armed;

    ep0_in_stage #(.MAX_PKT(MAXP), .ACK_TIMEOUT(TMO)) uut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int ready_mode = 0;       // 0 always ready, 1 alternating, 2 never
    logic [9:0] exp_q [$];    // {zlp, last, data}
    logic [7:0] model_q [$];  // bytes the firmware model expects stored

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // ready driver
    initial begin
        bit phase = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            phase = ~phase;
            case (ready_mode)
                0: tx_ready = 1'b1;
                1: tx_ready = phase;
                default: tx_ready = 1'b0;
            endcase
        end
    end

    // monitor: pops and compares beats on the handshake
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected beat", int'(tx_data), -1);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk({tx_zlp, tx_last, tx_data} == e, "R4/R8 beat",
                        int'({tx_zlp, tx_last, tx_data}), int'(e));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    task automatic fw_write(input logic [7:0] b);
        fw_wr_en = 1'b1;
        fw_wr_data = b;
        tick();
        fw_wr_en = 1'b0;
    endtask

    task automatic pulse_arm();     fw_arm = 1'b1;       tick(); fw_arm = 1'b0;       endtask
    task automatic pulse_sack();    fw_setup_ack = 1'b1; tick(); fw_setup_ack = 1'b0; endtask
    task automatic pulse_clr();     fw_done_clr = 1'b1;  tick(); fw_done_clr = 1'b0;  endtask
    task automatic pulse_setup();   tok_setup = 1'b1;    tick(); tok_setup = 1'b0;    endtask
    task automatic pulse_out();     tok_out = 1'b1;      tick(); tok_out = 1'b0;      endtask
    task automatic pulse_ack();     hs_ack = 1'b1;       tick(); hs_ack = 1'b0;       endtask

    task automatic in_token(output logic got_nak);
        tok_in = 1'b1;
        tick();
        got_nak = nak_out;
        tok_in = 1'b0;
    endtask

    task automatic load(input int n, input logic [7:0] base);
        model_q.delete();
        for (int i = 0; i < n; i++) begin
            fw_write(base + 8'(i));
            model_q.push_back(base + 8'(i));
        end
    endtask

    task automatic push_expected();
        if (model_q.size() == 0) begin
            exp_q.push_back({1'b1, 1'b1, 8'h00});
        end else begin
            for (int i = 0; i < model_q.size(); i++) begin
                exp_q.push_back({1'b0, i == model_q.size() - 1, model_q[i]});
            end
        end
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 200; i++) begin
            if (exp_q.size() == 0 && !tx_valid) break;
            tick();
        end
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic send_packet(input string req);
        logic n;
        push_expected();
        in_token(n);
        chk(n == 1'b0, {req, " IN accepted"}, int'(n), 0);
        drain(req);
    endtask

    initial begin
        logic n;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk({tx_valid, nak_out, done_flag, irq, wr_err, stage_done, armed} == '0,
            "R1 flags", int'({tx_valid, nak_out, done_flag, irq, wr_err, stage_done, armed}), 0);
        chk(fill_count == 0, "R1 fill_count", int'(fill_count), 0);

        // R7 overflow when full
        load(MAXP, 8'h10);
        chk(fill_count == MAXP, "R4 fill_count after loads", int'(fill_count), MAXP);
        chk(wr_err == 1'b0, "R7 no error yet", int'(wr_err), 0);
        fw_write(8'hEE);
        chk(fill_count == MAXP, "R7 full write dropped", int'(fill_count), MAXP);
        chk(wr_err == 1'b1, "R7 full write error", int'(wr_err), 1);

        // R2 armed but setup not acknowledged
        pulse_arm();
        in_token(n);
        chk(n == 1'b1, "R2 NAK without setup ack", int'(n), 1);
        tick();
        chk(armed == 1'b1 && !tx_valid, "R2 nothing sent", int'(tx_valid), 0);

        // R10 setup clears buffer, armed, error
        pulse_setup();
        chk(fill_count == 0 && !armed, "R10 buffer cleared", int'(fill_count), 0);
        chk(wr_err == 1'b0 && stage_done == 1'b0, "R10 error cleared", int'(wr_err), 0);

        // R3 IN with nothing armed
        pulse_sack();
        in_token(n);
        chk(n == 1'b1, "R3 NAK when not armed", int'(n), 1);
        chk(fill_count == 0 && !armed, "R3 state unchanged", int'(armed), 0);

        // R4 full packet, write while armed dropped (R7)
        load(MAXP, 8'hA0);
        pulse_arm();
        fw_write(8'h55);
        chk(wr_err == 1'b1, "R7 write while armed error", int'(wr_err), 1);
        chk(fill_count == MAXP, "R7 write while armed dropped", int'(fill_count), MAXP);
        ready_mode = 0;
        send_packet("R4 full packet");
        chk(done_flag == 1'b0, "R5 no flag before ack", int'(done_flag), 0);
        pulse_ack();
        chk(done_flag && irq, "R5 flag and irq on ack", int'({done_flag, irq}), 3);
        chk(fill_count == 0 && !armed, "R5 buffer released", int'(fill_count), 0);

        // R8 short packet under stall, ack and clear together (R6)
        ready_mode = 1;
        load(3, 8'h30);
        pulse_arm();
        send_packet("R8 short packet");
        hs_ack = 1'b1;
        fw_done_clr = 1'b1;
        tick();
        hs_ack = 1'b0;
        fw_done_clr = 1'b0;
        chk(done_flag == 1'b1, "R6 set wins over clear", int'(done_flag), 1);
        pulse_clr();
        chk(!done_flag && !irq, "R6 clear drops flag and irq", int'({done_flag, irq}), 0);

        // R8 zero-length packet
        ready_mode = 0;
        model_q.delete();
        pulse_arm();
        send_packet("R8 zero-length packet");
        pulse_ack();
        chk(done_flag == 1'b1, "R8 ZLP acknowledged", int'(done_flag), 1);
        pulse_clr();

        // R11 ack timeout, retransmit
        load(3, 8'h70);
        pulse_arm();
        send_packet("R11 first attempt");
        repeat (TMO + 4) tick();
        chk(done_flag == 1'b0, "R11 no flag on timeout", int'(done_flag), 0);
        chk(armed == 1'b1 && fill_count == 3, "R11 still armed", int'(fill_count), 3);
        send_packet("R11 retransmit");
        pulse_ack();
        chk(done_flag == 1'b1, "R11 flag after late ack", int'(done_flag), 1);

        // R9 OUT during stalled send
        ready_mode = 2;
        load(4, 8'hC0);
        pulse_arm();
        in_token(n);
        tick();
        chk(tx_valid == 1'b1, "R9 sending before OUT", int'(tx_valid), 1);
        pulse_out();
        chk(!tx_valid && stage_done, "R9 OUT ends stage", int'({tx_valid, stage_done}), 1);
        chk(fill_count == 0 && !armed, "R9 data flushed", int'(fill_count), 0);
        ready_mode = 0;

        // R10 setup keeps done flag, clears setup ack
        pulse_setup();
        chk(done_flag == 1'b1, "R10 done kept", int'(done_flag), 1);
        chk(stage_done == 1'b0, "R10 stage_done cleared", int'(stage_done), 0);
        load(1, 8'h99);
        pulse_arm();
        in_token(n);
        chk(n == 1'b1, "R10 setup ack cleared", int'(n), 1);
        tick();
        chk(!tx_valid, "R10 nothing sent", int'(tx_valid), 0);

        repeat (3) tick();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule